// File: doc/BRIEF.md
# Command-Indexed Cartridge Bank Mapper

This block sits on a game cartridge for an 8-bit console, between the console's CPU and video buses and the cartridge memories. Software changes the mapping in two steps. It first writes a command number into a latch, then writes a parameter byte that is applied to the latched command. Sixteen commands cover everything the block does: eight character windows, four program windows, the nametable arrangement, and three registers of an external interval timer.

The block turns each CPU address into a program-memory address, and it drives a ROM enable or a RAM enable. The lowest switchable program window can point at ROM or at work RAM. When RAM is chosen but not enabled, neither memory drives the bus. Video addresses below $2000 become character ROM addresses built from 1 KiB banks. A single output chooses which of the two nametable halves answers a video access. Parameter writes to the three timer commands leave the block as one-cycle strobes that carry the byte. The timer itself lies outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write with address bits 15:13 equal to 3'b100 ($8000-$9FFF) loads data bits 3:0 into the command latch. Data bits 7:4 are ignored.
- R2: A CPU write with address bits 15:13 equal to 3'b101 ($A000-$BFFF) applies the whole data byte to the latched command. This is the only write that changes a setting. Writes to any other address change nothing.
- R3: Commands 0 to 7 set the 8-bit bank of video window n = ppu_addr[12:10]. For ppu_addr[13]=0, chr_addr = {bank[n], ppu_addr[9:0]} and chr_ce=1. For ppu_addr[13]=1, chr_ce=0.
- R4: Command 8 bits 4:0 give the bank for $6000-$7FFF. When bit 6 is clear, that window reads ROM at {bank, cpu_addr[12:0]}.
- R5: When command 8 bit 6 is set, the $6000-$7FFF window selects RAM. prg_ram_ce is then high only if bit 7 is also set. With bit 7 clear, neither enable is driven. ROM and RAM enables are never high together.
- R6: Commands 9, A and B set the 5-bit banks for $8000, $A000 and $C000 respectively. Their data bits 7:5 are ignored.
- R7: In $E000-$FFFF, prg_rom_ce is high and the bank field of prg_addr is all ones.
- R8: Command C bits 1:0 select how nt_sel is formed. 0 gives ppu_addr[10], 1 gives ppu_addr[11], 2 gives constant 0 and 3 gives constant 1.
- R9: A parameter write to command D, E or F raises tmr_ctrl_we, tmr_lo_we or tmr_hi_we respectively for exactly the next cycle. In that cycle tmr_data carries the byte. At most one strobe is high at a time.
- R10: A synchronous active-low reset clears all banks, the command latch and both RAM bits, and sets mirroring to mode 0. No strobe is raised.
- R11: CPU addresses below $6000 assert neither prg_rom_ce nor prg_ram_ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write, one cycle per write |
| ppu_addr | input | 14 | Video-bus address |
| prg_addr | output | PRG_BW+13 | Program memory address |
| prg_rom_ce | output | 1 | Program ROM enable |
| prg_ram_ce | output | 1 | Work RAM enable |
| chr_addr | output | CHR_BW+10 | Character ROM address |
| chr_ce | output | 1 | Character ROM enable |
| nt_sel | output | 1 | Nametable half select |
| tmr_ctrl_we | output | 1 | Timer control write strobe |
| tmr_lo_we | output | 1 | Timer count low byte strobe |
| tmr_hi_we | output | 1 | Timer count high byte strobe |
| tmr_data | output | 8 | Byte carried with a timer strobe |

## Verification
The bench uses the default widths: 5-bit program banks and 8-bit character banks. At these widths a random data byte can reach every bank value. The masking of data bits 7:5 on program banks and of bits 7:4 on commands is exercised as well. Random addresses cover all eight CPU windows and all video windows. Together with directed programming of the RAM select and enable combinations, this reaches the open-bus case, all four mirroring modes and each timer strobe.

// File: rtl/cbm_pkg.sv
// Shared constants and types for the cartridge bank mapper.
// Assumes a 16-bit CPU address split into eight 8 KiB windows.
package cbm_pkg;
    localparam int CPU_AW      = 16;
    localparam int PPU_AW      = 14;
    localparam int PRG_OFF_W   = 13;
    localparam int CHR_OFF_W   = 10;
    localparam int NUM_CHR_WIN = 8;
    localparam int NUM_PRG_SW  = 4;

    localparam logic [2:0] WIN_LOW_RAM = 3'd3;
    localparam logic [2:0] WIN_CMD     = 3'd4;
    localparam logic [2:0] WIN_PARAM   = 3'd5;
    localparam logic [2:0] WIN_FIXED   = 3'd7;

    localparam logic [3:0] CMD_PRG_BASE = 4'h8;
    localparam logic [3:0] CMD_MIRROR   = 4'hC;
    localparam logic [3:0] CMD_TMR_CTRL = 4'hD;
    localparam logic [3:0] CMD_TMR_LO   = 4'hE;
    localparam logic [3:0] CMD_TMR_HI   = 4'hF;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;
endpackage

// File: rtl/cbm_cfg_regs.sv
// Command latch and the configuration entries it indexes.
// Assumes CHR_BW <= 8 and PRG_BW <= 5. A write lasts one clock.
// Timer commands leave as registered one-cycle strobes.
module cbm_cfg_regs
    import cbm_pkg::*;
#(
    parameter int CHR_BW = 8,
    parameter int PRG_BW = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [2:0]                            wr_win,
    input  logic [7:0]                            wr_data,
    output logic [NUM_CHR_WIN-1:0][CHR_BW-1:0]    chr_bank,
    output logic [NUM_PRG_SW-1:0][PRG_BW-1:0]     prg_bank,
    output logic                                  low_ram_sel,
    output logic                                  low_ram_en,
    output mirror_e                               mirror,
    output logic                                  tmr_ctrl_we,
    output logic                                  tmr_lo_we,
    output logic                                  tmr_hi_we,
    output logic [7:0]                            tmr_data
);
    logic [3:0] cmd_q;
    logic       cmd_wr;
    logic       par_wr;

    assign cmd_wr = wr_en && (wr_win == WIN_CMD);
    assign par_wr = wr_en && (wr_win == WIN_PARAM);

    // Latch the command number from the low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_wr) cmd_q <= wr_data[3:0];
    end

    // One bank entry per video window.
    for (genvar g = 0; g < NUM_CHR_WIN; g++) begin : g_chr
        // Load the character bank when its command is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chr_bank[g] <= '0;
            else if (par_wr && cmd_q == 4'(g))
                chr_bank[g] <= wr_data[CHR_BW-1:0];
        end
    end

    // One bank entry per switchable program window.
    for (genvar g = 0; g < NUM_PRG_SW; g++) begin : g_prg
        // Load the program bank when its command is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prg_bank[g] <= '0;
            else if (par_wr && cmd_q == CMD_PRG_BASE + 4'(g))
                prg_bank[g] <= wr_data[PRG_BW-1:0];
        end
    end

    // RAM select and enable for the lowest program window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_ram_sel <= 1'b0;
            low_ram_en  <= 1'b0;
        end else if (par_wr && cmd_q == CMD_PRG_BASE) begin
            low_ram_sel <= wr_data[6];
            low_ram_en  <= wr_data[7];
        end
    end

    // Nametable arrangement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror <= MIR_VERT;
        else if (par_wr && cmd_q == CMD_MIRROR)
            mirror <= mirror_e'(wr_data[1:0]);
    end

    // Timer strobes, one cycle after the parameter write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_ctrl_we <= 1'b0;
            tmr_lo_we   <= 1'b0;
            tmr_hi_we   <= 1'b0;
            tmr_data    <= '0;
        end else begin
            tmr_ctrl_we <= par_wr && (cmd_q == CMD_TMR_CTRL);
            tmr_lo_we   <= par_wr && (cmd_q == CMD_TMR_LO);
            tmr_hi_we   <= par_wr && (cmd_q == CMD_TMR_HI);
            if (par_wr) tmr_data <= wr_data;
        end
    end

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_ctrl_we, tmr_lo_we, tmr_hi_we}));
    a_r9_lo_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_lo_we |-> $past(par_wr && cmd_q == CMD_TMR_LO));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_hi_we |=> !tmr_hi_we || $past(par_wr));
    a_r1_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cmd_q));
    a_r2_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !par_wr |=> $stable(chr_bank) && $stable(prg_bank) && $stable(mirror));
endmodule

// File: rtl/cbm_prg_map.sv
// CPU address translation to program ROM or work RAM.
// Assumes the fixed top window maps to the last bank of a full-size ROM.
module cbm_prg_map
    import cbm_pkg::*;
#(
    parameter int PRG_BW = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CPU_AW-1:0]                 cpu_addr,
    input  logic [NUM_PRG_SW-1:0][PRG_BW-1:0] prg_bank,
    input  logic                              low_ram_sel,
    input  logic                              low_ram_en,
    output logic [PRG_BW+PRG_OFF_W-1:0]       prg_addr,
    output logic                              prg_rom_ce,
    output logic                              prg_ram_ce
);
    localparam int PA_W = PRG_BW + PRG_OFF_W;

    logic [2:0]        win;
    logic [PRG_BW-1:0] bank;

    assign win = cpu_addr[CPU_AW-1 -: 3];

    // Pick the bank and enables for the addressed window.
    always_comb begin
        bank       = '0;
        prg_rom_ce = 1'b0;
        prg_ram_ce = 1'b0;
        case (win)
            WIN_LOW_RAM: begin
                bank       = prg_bank[0];
                prg_rom_ce = !low_ram_sel;
                prg_ram_ce = low_ram_sel && low_ram_en;
            end
            3'd4: begin bank = prg_bank[1]; prg_rom_ce = 1'b1; end
            3'd5: begin bank = prg_bank[2]; prg_rom_ce = 1'b1; end
            3'd6: begin bank = prg_bank[3]; prg_rom_ce = 1'b1; end
            WIN_FIXED: begin bank = '1; prg_rom_ce = 1'b1; end
            default: ;
        endcase
    end

    assign prg_addr = {bank, cpu_addr[PRG_OFF_W-1:0]};

    a_r5_ce_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_rom_ce && prg_ram_ce));
    a_r5_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ram_ce |-> (cpu_addr[CPU_AW-1 -: 3] == WIN_LOW_RAM));
    a_r7_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1 -: 3] == WIN_FIXED) |->
            prg_rom_ce && (prg_addr[PA_W-1:PRG_OFF_W] == {PRG_BW{1'b1}}));
    a_r11_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> !prg_rom_ce && !prg_ram_ce);
endmodule

// File: rtl/cbm_chr_map.sv
// Video address translation to character ROM and the nametable select.
// Assumes pattern space is video addresses below $2000.
module cbm_chr_map
    import cbm_pkg::*;
#(
    parameter int CHR_BW = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [PPU_AW-1:0]                   ppu_addr,
    input  logic [NUM_CHR_WIN-1:0][CHR_BW-1:0]  chr_bank,
    input  mirror_e                             mirror,
    output logic [CHR_BW+CHR_OFF_W-1:0]         chr_addr,
    output logic                                chr_ce,
    output logic                                nt_sel
);
    assign chr_addr = {chr_bank[ppu_addr[12:10]], ppu_addr[CHR_OFF_W-1:0]};
    assign chr_ce   = !ppu_addr[13];

    // Form the nametable half select from the mirroring mode.
    always_comb begin
        case (mirror)
            MIR_VERT:   nt_sel = ppu_addr[10];
            MIR_HORZ:   nt_sel = ppu_addr[11];
            MIR_ONE_LO: nt_sel = 1'b0;
            default:    nt_sel = 1'b1;
        endcase
    end

    a_r8_single_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror == MIR_ONE_LO) |-> !nt_sel);
    a_r8_single_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror == MIR_ONE_HI) |-> nt_sel);
    a_r3_chr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[CHR_OFF_W-1:0] == ppu_addr[CHR_OFF_W-1:0]);
endmodule

// File: rtl/cart_bank_mapper.sv
// Top of the cartridge bank mapper: configuration entries plus the
// program and character address translators.
// Assumes one write per asserted cpu_wr cycle and no bus conflicts.
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_BW = 5,
    parameter int CHR_BW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 cpu_addr,
    input  logic [7:0]                  cpu_data,
    input  logic                        cpu_wr,
    input  logic [13:0]                 ppu_addr,
    output logic [PRG_BW+12:0]          prg_addr,
    output logic                        prg_rom_ce,
    output logic                        prg_ram_ce,
    output logic [CHR_BW+9:0]           chr_addr,
    output logic                        chr_ce,
    output logic                        nt_sel,
    output logic                        tmr_ctrl_we,
    output logic                        tmr_lo_we,
    output logic                        tmr_hi_we,
    output logic [7:0]                  tmr_data
);
    logic [NUM_CHR_WIN-1:0][CHR_BW-1:0] chr_bank;
    logic [NUM_PRG_SW-1:0][PRG_BW-1:0]  prg_bank;
    logic                               low_ram_sel;
    logic                               low_ram_en;
    mirror_e                            mirror;

    cbm_cfg_regs #(.CHR_BW(CHR_BW), .PRG_BW(PRG_BW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr),
        .wr_win(cpu_addr[15:13]), .wr_data(cpu_data),
        .chr_bank(chr_bank), .prg_bank(prg_bank),
        .low_ram_sel(low_ram_sel), .low_ram_en(low_ram_en), .mirror(mirror),
        .tmr_ctrl_we(tmr_ctrl_we), .tmr_lo_we(tmr_lo_we),
        .tmr_hi_we(tmr_hi_we), .tmr_data(tmr_data)
    );

    cbm_prg_map #(.PRG_BW(PRG_BW)) u_prg (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .prg_bank(prg_bank),
        .low_ram_sel(low_ram_sel), .low_ram_en(low_ram_en),
        .prg_addr(prg_addr), .prg_rom_ce(prg_rom_ce), .prg_ram_ce(prg_ram_ce)
    );

    cbm_chr_map #(.CHR_BW(CHR_BW)) u_chr (
        .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .chr_bank(chr_bank),
        .mirror(mirror), .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_sel(nt_sel)
    );
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
    localparam int PRG_BW = 5;
    localparam int CHR_BW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n = 1'b0;
    logic [15:0]         cpu_addr = '0;
    logic [7:0]          cpu_data = '0;
    logic                cpu_wr = 1'b0;
    logic [13:0]         ppu_addr = '0;
    logic [PRG_BW+12:0]  prg_addr;
    logic                prg_rom_ce, prg_ram_ce;
    logic [CHR_BW+9:0]   chr_addr;
    logic                chr_ce, nt_sel;
    logic                tmr_ctrl_we, tmr_lo_we, tmr_hi_we;
    logic [7:0]          tmr_data;

    cart_bank_mapper #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .prg_rom_ce(prg_rom_ce), .prg_ram_ce(prg_ram_ce), .chr_addr(chr_addr),
        .chr_ce(chr_ce), .nt_sel(nt_sel), .tmr_ctrl_we(tmr_ctrl_we),
        .tmr_lo_we(tmr_lo_we), .tmr_hi_we(tmr_hi_we), .tmr_data(tmr_data)
    );

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_cmd;
    int m_chr[8];
    int m_prg[4];
    bit m_rsel, m_ren;
    int m_mir;
    bit e_ctrl, e_lo, e_hi;
    int e_data;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_rsel = 0; m_ren = 0; m_mir = 0;
            foreach (m_chr[i]) m_chr[i] = 0;
            foreach (m_prg[i]) m_prg[i] = 0;
            e_ctrl = 0; e_lo = 0; e_hi = 0; e_data = 0;
        end else begin
            e_ctrl = 0; e_lo = 0; e_hi = 0;
            if (cpu_wr && cpu_addr[15:13] == 3'd4) begin
                m_cmd = int'(cpu_data) & 15;
            end else if (cpu_wr && cpu_addr[15:13] == 3'd5) begin
                if (m_cmd < 8) m_chr[m_cmd] = int'(cpu_data);
                else if (m_cmd == 8) begin
                    m_prg[0] = int'(cpu_data) & 31;
                    m_rsel = cpu_data[6];
                    m_ren  = cpu_data[7];
                end else if (m_cmd < 12) m_prg[m_cmd-8] = int'(cpu_data) & 31;
                else if (m_cmd == 12) m_mir = int'(cpu_data) & 3;
                else begin
                    e_ctrl = (m_cmd == 13);
                    e_lo   = (m_cmd == 14);
                    e_hi   = (m_cmd == 15);
                    e_data = int'(cpu_data);
                end
            end
        end
    end

    // Compare every output against the model each cycle.
    always @(negedge clk) begin
        #1;
        if (live && rst_n) begin
            int w;
            int eb;
            bit er, em, ent;
            string tg;
            w = int'(cpu_addr[15:13]);
            eb = 0; er = 0; em = 0; tg = "R11";
            if (w == 3) begin
                eb = m_prg[0]; er = !m_rsel; em = m_rsel && m_ren;
                tg = m_rsel ? "R5" : "R4";
            end else if (w >= 4 && w <= 6) begin
                eb = m_prg[w-3]; er = 1; tg = "R6";
            end else if (w == 7) begin
                eb = (1 << PRG_BW) - 1; er = 1; tg = "R7";
            end
            chk(tg, prg_rom_ce, er);
            chk(tg, prg_ram_ce, em);
            if (er || em) chk(tg, prg_addr, eb * 8192 + int'(cpu_addr[12:0]));
            chk("R3", chr_ce, !ppu_addr[13]);
            if (!ppu_addr[13])
                chk("R3", chr_addr, m_chr[ppu_addr[12:10]] * 1024 + int'(ppu_addr[9:0]));
            case (m_mir)
                0: ent = ppu_addr[10];
                1: ent = ppu_addr[11];
                2: ent = 0;
                default: ent = 1;
            endcase
            chk("R8", nt_sel, ent);
            chk("R9", {tmr_ctrl_we, tmr_lo_we, tmr_hi_we}, {e_ctrl, e_lo, e_hi});
            if (e_ctrl || e_lo || e_hi) chk("R9", tmr_data, e_data);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R10: state after reset
        cpu_addr = 16'h6123; ppu_addr = 14'h0C05;
        settle();
        chk("R10", prg_rom_ce, 1);
        chk("R10", prg_ram_ce, 0);
        chk("R10", prg_addr, 16'h0123);
        chk("R10", chr_addr, 10'h005);
        chk("R10", nt_sel, 1);
        chk("R10", {tmr_ctrl_we, tmr_lo_we, tmr_hi_we}, 0);

        // R1: high nibble of the command byte is ignored
        wr(16'h9ABC, 8'hF3);
        wr(16'hB001, 8'h5A);
        cpu_addr = 16'h0000; ppu_addr = 14'h0C05;
        settle();
        chk("R1", chr_addr, (18'h5A << 10) | 18'h005);

        // R2: writes outside the command/parameter windows do nothing
        wr(16'hC000, 8'h77);
        wr(16'h6000, 8'h11);
        wr(16'hE000, 8'h22);
        wr(16'h1234, 8'h33);
        ppu_addr = 14'h0C05;
        settle();
        chk("R2", chr_addr, (18'h5A << 10) | 18'h005);

        // R4 / R5: ROM, RAM disabled, RAM enabled
        wr(16'h8000, 8'h08);
        wr(16'hA000, 8'h27);
        cpu_addr = 16'h7001;
        settle();
        chk("R4", prg_rom_ce, 1);
        chk("R4", prg_addr, (7 << 13) | 16'h1001);
        wr(16'hA000, 8'h42);
        cpu_addr = 16'h7001;
        settle();
        chk("R5", {prg_rom_ce, prg_ram_ce}, 2'b00);
        wr(16'hA000, 8'hC2);
        cpu_addr = 16'h7001;
        settle();
        chk("R5", {prg_rom_ce, prg_ram_ce}, 2'b01);
        chk("R5", prg_addr, (2 << 13) | 16'h1001);

        // R6: upper data bits dropped on program banks
        wr(16'h8000, 8'h0B);
        wr(16'hA000, 8'hFE);
        cpu_addr = 16'hC010;
        settle();
        chk("R6", prg_addr, (30 << 13) | 16'h0010);

        // R8: each mirroring mode
        for (int m = 0; m < 4; m++) begin
            wr(16'h8000, 8'h0C);
            wr(16'hA000, 8'(m));
            ppu_addr = 14'h2800;
            settle();
            chk("R8", nt_sel, (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 0 : 1);
        end

        // R9: low-byte strobe for one cycle
        wr(16'h8000, 8'h0E);
        wr(16'hA000, 8'h9C);
        #1;
        chk("R9", {tmr_ctrl_we, tmr_lo_we, tmr_hi_we}, 3'b010);
        chk("R9", tmr_data, 8'h9C);
        settle();
        chk("R9", {tmr_ctrl_we, tmr_lo_we, tmr_hi_we}, 3'b000);

        // Random traffic against the model.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            cpu_addr = 16'($urandom);
            ppu_addr = 14'($urandom);
            cpu_data = 8'($urandom);
            cpu_wr   = ($urandom % 3 == 0);
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        settle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule